// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial PHY out of reset and confirms that its receive PLL has locked. After a start pulse it runs one of two variants. In the indirect variant it drives an external transaction master. That master gives access to the PHY's internal register space through three transaction kinds: address capture, data write and data read. The block selects the clock/reset register and writes its reset bit. It then waits, selects the lane output status register and reads it, and repeats that wait/select/read until the lock bit is seen or the retry budget runs out. In the direct variant it never touches the register port. Instead it drives two dedicated control lines, a software power-down and a software reset, with a fixed reset hold time.

Each run ends with a one-cycle done pulse. Exactly one of three result flags is then raised: success, timeout or transaction error. The flags hold until the next accepted start. The wait between lock polls, the reset hold time and the retry budget are parameters counted in clock cycles.

Top module: `phy_lock_seq`

## Requirements
- R1: Out of reset, txn_req_o, done_o, ok_o, timeout_o and err_o are 0, and both dedicated lines pwrdn_o and swrst_o are 1.
- R2: With variant_i=0, the first transaction is an address capture (op code 0) with data 0x7F3F, and the second is a data write (op code 1) with data 0x0001.
- R3: After the reset write completes, no request is raised for POLL_WAIT_CYC cycles. Each poll is then an address capture of 0x2003 followed by a data read (op code 2). The read request rises two cycles after the address completes, and the next poll's address request rises POLL_WAIT_CYC+2 cycles after an unlocked read completes.
- R4: A read whose data has bit 1 set ends the run with done_o and ok_o=1, and no further request is raised.
- R5: At most MAX_TRIES reads are made. If none shows bit 1 set, the run ends with timeout_o=1 and no further request is raised.
- R6: A completion with txn_err_i=1 on any transaction ends the run at once with err_o=1, and no further request is raised.
- R7: txn_req_o, txn_op_o and txn_wdata_o hold steady from the rise of a request until the cycle in which txn_done_i is seen. txn_req_o is low in the following cycle.
- R8: With variant_i=1, no request is raised. pwrdn_o and swrst_o go to 0 in the cycle after start, and swrst_o stays 0 for exactly HOLD_CYC cycles. swrst_o then returns to 1 in the same cycle as done_o with ok_o=1. pwrdn_o stays 0.
- R9: done_o is high for exactly one cycle per run. The result flags are mutually exclusive, hold until the next accepted start, and are cleared in the cycle after that start.
- R10: A start pulse that arrives while a run is in progress is ignored: the transaction sequence, the result and the dedicated lines are unaffected.
- R11: Only bit 1 of the read data decides lock. A read with every other bit set but bit 1 clear counts as unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| variant_i | input | 1 | 0: register-port sequence, 1: dedicated-line sequence |
| txn_req_o | output | 1 | Transaction request, held until completion |
| txn_op_o | output | 2 | Transaction kind: 0 address, 1 write, 2 read |
| txn_wdata_o | output | 16 | Register address or write data |
| txn_done_i | input | 1 | Transaction completion, one cycle |
| txn_err_i | input | 1 | Completion carries an error, valid with txn_done_i |
| txn_rdata_i | input | 16 | Read data, valid with txn_done_i |
| pwrdn_o | output | 1 | Software power-down line |
| swrst_o | output | 1 | Software reset line (0 holds the PHY in reset) |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_o | output | 1 | Run succeeded |
| timeout_o | output | 1 | Lock never seen within the retry budget |
| err_o | output | 1 | A transaction completed with error |

## Verification
The assertions assume that the master raises txn_done_i only while a request is pending, for a single cycle per transaction. They also assume that txn_err_i and txn_rdata_i are only meaningful alongside txn_done_i. The bench's master model answers each request once, after a fixed latency, and drops its completion in the next cycle. Start pulses last one cycle, and some arrive in mid-run on purpose. Lock timing, error position and read-data noise are varied per scenario so that every exit of the poll loop is reached.

// File: rtl/phy_lock_seq_pkg.sv
package phy_lock_seq_pkg;

    localparam int unsigned REG_W = 16;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } txn_op_e;

    typedef struct packed {
        txn_op_e            op;
        logic [REG_W-1:0]   data;
    } txn_cmd_t;

    typedef struct packed {
        logic               valid;
        logic               err;
        logic [REG_W-1:0]   rdata;
    } txn_rsp_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT_RSP,
        ST_DELAY,
        ST_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        STEP_RST_SEL,
        STEP_RST_WR,
        STEP_LANE_SEL,
        STEP_LANE_RD
    } seq_step_e;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_OK,
        RES_TIMEOUT,
        RES_FAIL
    } seq_result_e;

    function automatic txn_cmd_t step_cmd(
        input seq_step_e        step,
        input logic [REG_W-1:0] rst_reg,
        input logic [REG_W-1:0] rst_val,
        input logic [REG_W-1:0] lane_reg
    );
        txn_cmd_t c;
        case (step)
            STEP_RST_SEL:  begin c.op = OP_ADDR;  c.data = rst_reg;  end
            STEP_RST_WR:   begin c.op = OP_WRITE; c.data = rst_val;  end
            STEP_LANE_SEL: begin c.op = OP_ADDR;  c.data = lane_reg; end
            default:       begin c.op = OP_READ;  c.data = '0;       end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/phy_lock_seq_txn.sv
module phy_lock_seq_txn
    import phy_lock_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  txn_cmd_t            cmd,
    output logic                req_o,
    output txn_op_e             op_o,
    output logic [REG_W-1:0]    data_o,
    input  logic                done_i,
    input  logic                err_i,
    input  logic [REG_W-1:0]    rdata_i,
    output txn_rsp_t            rsp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_o  <= 1'b0;
            op_o   <= OP_ADDR;
            data_o <= '0;
        end else if (cmd_valid) begin
            req_o  <= 1'b1;
            op_o   <= cmd.op;
            data_o <= cmd.data;
        end else if (req_o && done_i) begin
            req_o  <= 1'b0;
        end
    end

    always_comb begin
        rsp.valid = req_o & done_i;
        rsp.err   = err_i;
        rsp.rdata = rdata_i;
    end

    // R7: request fields steady until completion
    p_req_stable_r7: assert property (@(posedge clk) disable iff (rst)
        req_o && !done_i |=> req_o && $stable(op_o) && $stable(data_o));

    // R7: request released right after completion
    p_req_release_r7: assert property (@(posedge clk) disable iff (rst)
        req_o && done_i |=> !req_o);

endmodule

// File: rtl/phy_lock_seq_timer.sv
module phy_lock_seq_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R3/R8: count only moves down except on a reload
    p_cnt_down_r3: assert property (@(posedge clk) disable iff (rst)
        !load && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/phy_lock_seq_tries.sv
module phy_lock_seq_tries #(
    parameter int unsigned MAX_TRIES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int unsigned TW = $clog2(MAX_TRIES + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == TW'(MAX_TRIES - 1));

    // R5: retry budget never overrun
    p_tries_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q < TW'(MAX_TRIES));

endmodule

// File: rtl/phy_lock_seq.sv
module phy_lock_seq
    import phy_lock_seq_pkg::*;
#(
    parameter int unsigned      POLL_WAIT_CYC = 5000,
    parameter int unsigned      HOLD_CYC      = 2500,
    parameter int unsigned      MAX_TRIES     = 10,
    parameter logic [15:0]      RST_REG       = 16'h7F3F,
    parameter logic [15:0]      RST_VAL       = 16'h0001,
    parameter logic [15:0]      LANE_REG      = 16'h2003,
    parameter int unsigned      LOCK_BIT      = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        variant_i,
    output logic        txn_req_o,
    output logic [1:0]  txn_op_o,
    output logic [15:0] txn_wdata_o,
    input  logic        txn_done_i,
    input  logic        txn_err_i,
    input  logic [15:0] txn_rdata_i,
    output logic        pwrdn_o,
    output logic        swrst_o,
    output logic        done_o,
    output logic        ok_o,
    output logic        timeout_o,
    output logic        err_o
);

    localparam int unsigned MAX_CNT = (POLL_WAIT_CYC > HOLD_CYC) ? POLL_WAIT_CYC : HOLD_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] POLL_LOAD = CNT_W'(POLL_WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);

    seq_state_e  state_q, state_d;
    seq_step_e   step_q, step_d;
    seq_result_e res_q, res_d;
    logic        done_q, done_d;
    logic        pwrdn_q, pwrdn_d;
    logic        swrst_q, swrst_d;

    logic              cmd_valid;
    txn_cmd_t          cmd;
    txn_rsp_t          rsp;
    txn_op_e           op_w;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              tries_clr, tries_inc, tries_last;
    logic              locked;
    logic              unused_rdata;

    assign cmd    = step_cmd(step_q, RST_REG, RST_VAL, LANE_REG);
    assign locked = rsp.rdata[LOCK_BIT];
    assign unused_rdata = ^rsp.rdata;

    phy_lock_seq_txn u_txn (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .req_o     (txn_req_o),
        .op_o      (op_w),
        .data_o    (txn_wdata_o),
        .done_i    (txn_done_i),
        .err_i     (txn_err_i),
        .rdata_i   (txn_rdata_i),
        .rsp       (rsp)
    );

    assign txn_op_o = op_w;

    phy_lock_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    phy_lock_seq_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk  (clk),
        .rst  (rst),
        .clr  (tries_clr),
        .inc  (tries_inc),
        .last (tries_last)
    );

    always_comb begin
        state_d   = state_q;
        step_d    = step_q;
        res_d     = res_q;
        done_d    = 1'b0;
        pwrdn_d   = pwrdn_q;
        swrst_d   = swrst_q;
        cmd_valid = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = POLL_LOAD;
        tries_clr = 1'b0;
        tries_inc = 1'b0;

        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    res_d     = RES_NONE;
                    tries_clr = 1'b1;
                    if (variant_i) begin
                        pwrdn_d  = 1'b0;
                        swrst_d  = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = HOLD_LOAD;
                        state_d  = ST_HOLD;
                    end else begin
                        step_d  = STEP_RST_SEL;
                        state_d = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                cmd_valid = 1'b1;
                state_d   = ST_WAIT_RSP;
            end
            ST_WAIT_RSP: begin
                if (rsp.valid) begin
                    if (rsp.err) begin
                        res_d   = RES_FAIL;
                        done_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        case (step_q)
                            STEP_RST_SEL: begin
                                step_d  = STEP_RST_WR;
                                state_d = ST_ISSUE;
                            end
                            STEP_RST_WR: begin
                                tmr_load = 1'b1;
                                state_d  = ST_DELAY;
                            end
                            STEP_LANE_SEL: begin
                                step_d  = STEP_LANE_RD;
                                state_d = ST_ISSUE;
                            end
                            default: begin
                                if (locked) begin
                                    res_d   = RES_OK;
                                    done_d  = 1'b1;
                                    state_d = ST_IDLE;
                                end else if (tries_last) begin
                                    res_d   = RES_TIMEOUT;
                                    done_d  = 1'b1;
                                    state_d = ST_IDLE;
                                end else begin
                                    tries_inc = 1'b1;
                                    tmr_load  = 1'b1;
                                    state_d   = ST_DELAY;
                                end
                            end
                        endcase
                    end
                end
            end
            ST_DELAY: begin
                if (tmr_expired) begin
                    step_d  = STEP_LANE_SEL;
                    state_d = ST_ISSUE;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    swrst_d = 1'b1;
                    res_d   = RES_OK;
                    done_d  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= STEP_RST_SEL;
            res_q   <= RES_NONE;
            done_q  <= 1'b0;
            pwrdn_q <= 1'b1;
            swrst_q <= 1'b1;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            res_q   <= res_d;
            done_q  <= done_d;
            pwrdn_q <= pwrdn_d;
            swrst_q <= swrst_d;
        end
    end

    assign done_o    = done_q;
    assign ok_o      = (res_q == RES_OK);
    assign timeout_o = (res_q == RES_TIMEOUT);
    assign err_o     = (res_q == RES_FAIL);
    assign pwrdn_o   = pwrdn_q;
    assign swrst_o   = swrst_q;

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: result flags only move on a finish or an accepted start
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable({ok_o, timeout_o, err_o}) |-> done_o || $past(start_i));

    // R8: the dedicated-line variant never uses the register port
    p_hold_no_req_r8: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_HOLD |-> !txn_req_o);

    // R8: reset line release coincides with a successful finish
    p_swrst_release_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(swrst_o) |-> done_o && ok_o);

    // R4/R5/R6: no request is outstanding once a run has finished
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !txn_req_o);

endmodule

// File: tb/phy_lock_seq_tb.sv
module phy_lock_seq_tb;

    localparam int W      = 16;
    localparam int HOLD   = 40;
    localparam int TRIES  = 10;
    localparam int M_LAT  = 1;
    localparam int NEVER  = 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        variant_i = 1'b0;
    logic        txn_req_o;
    logic [1:0]  txn_op_o;
    logic [15:0] txn_wdata_o;
    logic        txn_done_i = 1'b0;
    logic        txn_err_i = 1'b0;
    logic [15:0] txn_rdata_i = '0;
    logic        pwrdn_o, swrst_o, done_o, ok_o, timeout_o, err_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // master model state
    logic [1:0]  lg_op  [64];
    logic [15:0] lg_dat [64];
    int          lg_seen[64];
    int          lg_done[64];
    int n_txn = 0;
    int n_rd  = 0;
    int lat   = 0;
    int lock_after = 0;
    int err_at = -1;
    logic [15:0] noise = '0;

    phy_lock_seq #(
        .POLL_WAIT_CYC (W),
        .HOLD_CYC      (HOLD),
        .MAX_TRIES     (TRIES)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .variant_i   (variant_i),
        .txn_req_o   (txn_req_o),
        .txn_op_o    (txn_op_o),
        .txn_wdata_o (txn_wdata_o),
        .txn_done_i  (txn_done_i),
        .txn_err_i   (txn_err_i),
        .txn_rdata_i (txn_rdata_i),
        .pwrdn_o     (pwrdn_o),
        .swrst_o     (swrst_o),
        .done_o      (done_o),
        .ok_o        (ok_o),
        .timeout_o   (timeout_o),
        .err_o       (err_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst) begin
            txn_done_i = 1'b0;
            txn_err_i  = 1'b0;
            lat        = 0;
        end else if (txn_done_i) begin
            txn_done_i  = 1'b0;
            txn_err_i   = 1'b0;
            txn_rdata_i = '0;
        end else if (txn_req_o) begin
            if (lat == 0 && n_txn < 64) lg_seen[n_txn] = cyc;
            if (lat < M_LAT) begin
                lat = lat + 1;
            end else begin
                lat = 0;
                if (n_txn < 64) begin
                    lg_op[n_txn]   = txn_op_o;
                    lg_dat[n_txn]  = txn_wdata_o;
                    lg_done[n_txn] = cyc;
                end
                if (txn_op_o == 2'd2) begin
                    txn_rdata_i = (n_rd >= lock_after) ? (noise | 16'h0002)
                                                       : (noise & ~16'h0002);
                    n_rd = n_rd + 1;
                end
                txn_err_i  = (n_txn == err_at);
                n_txn      = n_txn + 1;
                txn_done_i = 1'b1;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks = checks + 1;
        fails  = fails + 1;
        $display("FAIL watchdog: run hung (actual cycles=%0d expected<150000)", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input bit cond, input string rq, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!cond) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic setup(input int la, input int ea, input logic [15:0] nz);
        @(negedge clk);
        n_txn = 0;
        n_rd = 0;
        lock_after = la;
        err_at = ea;
        noise = nz;
    endtask

    task automatic pulse_start(input logic v);
        @(negedge clk);
        start_i = 1'b1;
        variant_i = v;
        @(negedge clk);
        start_i = 1'b0;
        variant_i = 1'b0;
    endtask

    task automatic wait_done(input string rq);
        int n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done_o == 1'b1, rq, "done seen", done_o, 1);
    endtask

    task automatic chk_flags(input string rq, input logic o, input logic t, input logic e);
        chk({ok_o, timeout_o, err_o} == {o, t, e}, rq, "flags ok/to/err",
            {ok_o, timeout_o, err_o}, {o, t, e});
    endtask

    task automatic t_reset();
        chk(txn_req_o == 0 && done_o == 0, "R1", "req/done after reset",
            {txn_req_o, done_o}, 0);
        chk_flags("R1", 0, 0, 0);
        chk(pwrdn_o == 1 && swrst_o == 1, "R1", "lines after reset",
            {pwrdn_o, swrst_o}, 2'b11);
    endtask

    task automatic t_lock_first();
        setup(0, -1, 16'h0000);
        pulse_start(1'b0);
        wait_done("R4");
        chk_flags("R4", 1, 0, 0);
        @(negedge clk);
        chk(done_o == 0, "R9", "done width", done_o, 0);
        repeat (5) @(negedge clk);
        chk(n_txn == 4, "R4", "txn count", n_txn, 4);
        chk(lg_op[0] == 2'd0 && lg_dat[0] == 16'h7F3F, "R2", "first txn",
            {lg_op[0], lg_dat[0]}, {2'd0, 16'h7F3F});
        chk(lg_op[1] == 2'd1 && lg_dat[1] == 16'h0001, "R2", "second txn",
            {lg_op[1], lg_dat[1]}, {2'd1, 16'h0001});
        chk(lg_op[2] == 2'd0 && lg_dat[2] == 16'h2003, "R3", "poll address",
            {lg_op[2], lg_dat[2]}, {2'd0, 16'h2003});
        chk(lg_op[3] == 2'd2, "R3", "poll read op", lg_op[3], 2);
        chk(lg_seen[2] - lg_done[1] == W + 2, "R3", "gap after reset write",
            lg_seen[2] - lg_done[1], W + 2);
        chk(lg_seen[3] - lg_done[2] == 2, "R3", "gap address to read",
            lg_seen[3] - lg_done[2], 2);
        chk(lg_seen[1] - lg_done[0] == 2, "R7", "request low between txns",
            lg_seen[1] - lg_done[0], 2);
        // R9: flags held long after done
        repeat (20) @(negedge clk);
        chk_flags("R9", 1, 0, 0);
    endtask

    task automatic t_lock_later_noise();
        setup(3, -1, 16'hFFFD);
        pulse_start(1'b0);
        // R9: flags cleared the cycle after an accepted start
        chk_flags("R9", 0, 0, 0);
        wait_done("R11");
        chk_flags("R11", 1, 0, 0);
        repeat (5) @(negedge clk);
        chk(n_txn == 2 + 2 * 4, "R11", "txn count with noisy unlocked reads",
            n_txn, 10);
        chk(lg_seen[4] - lg_done[3] == W + 2, "R3", "gap between polls",
            lg_seen[4] - lg_done[3], W + 2);
        chk(lg_op[8] == 2'd0 && lg_dat[8] == 16'h2003 && lg_op[9] == 2'd2, "R3",
            "fourth poll pair", {lg_op[8], lg_dat[8]}, {2'd0, 16'h2003});
    endtask

    task automatic t_timeout();
        int snap;
        setup(NEVER, -1, 16'h0000);
        pulse_start(1'b0);
        wait_done("R5");
        chk_flags("R5", 0, 1, 0);
        chk(n_rd == TRIES, "R5", "read count", n_rd, TRIES);
        snap = n_txn;
        repeat (3 * W) @(negedge clk);
        chk(n_txn == snap && txn_req_o == 0, "R5", "no txn after timeout",
            n_txn, snap);
        chk(snap == 2 + 2 * TRIES, "R5", "total txns", snap, 2 + 2 * TRIES);
    endtask

    task automatic t_error(input int at, input string tag);
        setup(NEVER, at, 16'h0000);
        pulse_start(1'b0);
        wait_done("R6");
        chk_flags("R6", 0, 0, 1);
        repeat (3 * W) @(negedge clk);
        chk(n_txn == at + 1, "R6", tag, n_txn, at + 1);
    endtask

    task automatic t_busy_start();
        setup(2, -1, 16'h0000);
        pulse_start(1'b0);
        repeat (10) @(negedge clk);
        pulse_start(1'b1);
        chk(pwrdn_o == 1 && swrst_o == 1, "R10", "lines untouched by busy start",
            {pwrdn_o, swrst_o}, 2'b11);
        wait_done("R10");
        chk_flags("R10", 1, 0, 0);
        repeat (3 * W) @(negedge clk);
        chk(n_txn == 8, "R10", "txn count with ignored start", n_txn, 8);
    endtask

    task automatic t_variant();
        int low = 0;
        int reqs = 0;
        setup(0, -1, 16'h0000);
        pulse_start(1'b1);
        chk(pwrdn_o == 0 && swrst_o == 0, "R8", "lines cleared after start",
            {pwrdn_o, swrst_o}, 0);
        chk_flags("R9", 0, 0, 0);
        for (int i = 0; i < 5000 && !done_o; i++) begin
            if (!swrst_o) low++;
            if (txn_req_o) reqs++;
            @(negedge clk);
        end
        chk(done_o == 1, "R8", "done after hold", done_o, 1);
        chk(low == HOLD, "R8", "reset hold cycles", low, HOLD);
        chk(swrst_o == 1 && ok_o == 1, "R8", "release with ok",
            {swrst_o, ok_o}, 2'b11);
        chk(reqs == 0 && n_txn == 0, "R8", "no port traffic", n_txn, 0);
        repeat (10) @(negedge clk);
        chk(pwrdn_o == 0, "R8", "power-down stays cleared", pwrdn_o, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lock_first();
        t_lock_later_noise();
        t_timeout();
        t_error(0, "error on reset address");
        t_error(1, "error on reset write");
        t_error(4, "error on second poll address");
        t_busy_start();
        t_variant();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule